// File: doc/BRIEF.md
# Two-Queue Converter Interrupt Arbiter

This block collects the interrupt events of a converter that runs two command queues and presents them to a bus master as one prioritized request level. The conversion engine reports each result write with a strobe. The strobe carries the queue number and two markers: the command was the last one in its queue, or the command had its pause bit set. From these, the block keeps four sticky flags, a completion flag and a pause flag for each queue. Each flag has its own enable bit.

Each queue has a 3-bit request level, and a level of zero mutes that queue. The block drives the highest level among enabled, pending sources toward the bus master. When the master acknowledges a level, the block answers only if a pending queue is programmed to that level. It then returns a vector that names the winning source. Software programs and inspects the block through a small strobed register port. It clears flags by writing ones to them.

Top module: `qirq_arbiter`

## Requirements
- R1: A result strobe (`res_wr`=1) with `res_last`=1 sets the completion flag of queue `res_queue` (0 = first queue, 1 = second queue). Flag bit 0 is the first queue's completion flag and bit 2 is the second queue's.
- R2: A result strobe with `res_pause`=1 sets that queue's pause flag (bit 1 for the first queue, bit 3 for the second). A strobe carrying both markers sets both flags of the queue.
- R3: Writing the flag register (address 2) clears every flag whose data bit is 1. Bits written as 0 leave their flags unchanged. If a flag is set and cleared in the same cycle, it stays set.
- R4: `irq_level` is the largest queue level among sources that are pending, enabled and on a queue with a nonzero level. It is 0 when no such source exists. It follows a flag, enable or level change one clock later.
- R5: A queue whose level field is 0 raises no request, and the block never answers an acknowledge on its behalf. Its flags still set.
- R6: An enable bit of 0 (enable register address 1, same bit order as the flags) blocks that source's request but not its flag.
- R7: When `iack` is high and `iack_level` equals the level of a queue with a requesting source, the block drives `iack_resp`=1 one clock later. At the same time it drives `iack_vec` = {vector base, source index}, where the index is 0 for first-queue completion, 1 for first-queue pause, 2 for second-queue completion and 3 for second-queue pause.
- R8: Among matching requesting sources, the lowest index wins. This puts the first queue ahead of the second, and completion ahead of pause within a queue, including when both queues share one level.
- R9: An acknowledge that matches no requesting source gives `iack_resp`=0 and `iack_vec`=0.
- R10: The registers read back one clock after `reg_addr` is presented on `reg_rdata`. Address 0 holds the first queue's level in bits 2:0 and the second queue's level in bits 5:3. Address 1 holds the enables. Address 2 holds the flags. Address 3 holds the vector base in bits 7:2. All read as 0 after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |
| res_wr | input | 1 | Result-write strobe from the conversion engine |
| res_queue | input | 1 | Queue number of the result |
| res_last | input | 1 | Result belongs to the last command of its queue |
| res_pause | input | 1 | Result belongs to a command with its pause bit set |
| irq_level | output | 3 | Prioritized request level, 0 when idle |
| iack | input | 1 | Acknowledge cycle strobe |
| iack_level | input | 3 | Level being acknowledged |
| iack_resp | output | 1 | Block answers the acknowledge |
| iack_vec | output | 8 | Vector of the winning source |

## Verification
A result strobe that sets a flag can arrive in the same cycle as a software write that clears that same flag. The bench provokes this by driving a last-command strobe for the second queue together with a write of 1 to bit 2 of the flag register. It then reads the flag register and expects bit 2 still set, and checks that the request level is unchanged. A second overlap, two queues pending at one shared level when an acknowledge arrives, is judged by the vector, which must name the first queue's source.

// File: rtl/qirq_pkg.sv
package qirq_pkg;
  localparam int SRC_PER_Q = 2;   // completion, pause
  localparam int KIND_CMP  = 0;
  localparam int KIND_PAU  = 1;

  typedef enum logic [1:0] {
    REG_LEVEL  = 2'd0,
    REG_ENABLE = 2'd1,
    REG_FLAG   = 2'd2,
    REG_VBASE  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/qirq_regs.sv
module qirq_regs
  import qirq_pkg::*;
#(
  parameter int NQ    = 2,
  parameter int LVL_W = 3,
  parameter int DW    = 8,
  parameter int VEC_W = 8,
  localparam int NS   = NQ * SRC_PER_Q,
  localparam int IW   = $clog2(NS),
  localparam int BW   = VEC_W - IW
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      reg_wr,
  input  logic [1:0]                reg_addr,
  input  logic [DW-1:0]             reg_wdata,
  input  logic [NS-1:0]             flags,
  output logic [NQ-1:0][LVL_W-1:0]  q_level,
  output logic [NS-1:0]             src_en,
  output logic [BW-1:0]             vec_base,
  output logic [NS-1:0]             flag_clr,
  output logic [DW-1:0]             reg_rdata
);
  logic [DW-1:0] rd_mux;

  // write-one-to-clear strobe toward the flag bank
  always_comb begin
    flag_clr = '0;
    if (reg_wr && reg_sel_e'(reg_addr) == REG_FLAG)
      flag_clr = reg_wdata[NS-1:0];
  end

  always_comb begin
    rd_mux = '0;
    case (reg_sel_e'(reg_addr))
      REG_LEVEL:  rd_mux[NQ*LVL_W-1:0] = q_level;
      REG_ENABLE: rd_mux[NS-1:0]       = src_en;
      REG_FLAG:   rd_mux[NS-1:0]       = flags;
      default:    rd_mux[VEC_W-1:IW]   = vec_base;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q_level   <= '0;
      src_en    <= '0;
      vec_base  <= '0;
      reg_rdata <= '0;
    end else begin
      reg_rdata <= rd_mux;
      if (reg_wr) begin
        case (reg_sel_e'(reg_addr))
          REG_LEVEL: begin
            for (int q = 0; q < NQ; q++)
              q_level[q] <= reg_wdata[q*LVL_W +: LVL_W];
          end
          REG_ENABLE: src_en   <= reg_wdata[NS-1:0];
          REG_VBASE:  vec_base <= reg_wdata[VEC_W-1:IW];
          default: ;
        endcase
      end
    end
  end

  // R10: a written level field reads back unchanged in later cycles
  p_level_wr_r10: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_sel_e'(reg_addr) == REG_LEVEL)
      |=> (q_level == $past(reg_wdata[NQ*LVL_W-1:0])))
    else $error("p_level_wr_r10");
endmodule

// File: rtl/qirq_flags.sv
module qirq_flags
  import qirq_pkg::*;
#(
  parameter int NQ  = 2,
  localparam int NS = NQ * SRC_PER_Q,
  localparam int QW = (NQ > 1) ? $clog2(NQ) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          res_wr,
  input  logic [QW-1:0] res_queue,
  input  logic          res_last,
  input  logic          res_pause,
  input  logic [NS-1:0] flag_clr,
  output logic [NS-1:0] flags
);
  logic [NS-1:0] flag_set;

  for (genvar q = 0; q < NQ; q++) begin : g_q
    assign flag_set[q*SRC_PER_Q + KIND_CMP] = res_wr && (res_queue == QW'(q)) && res_last;
    assign flag_set[q*SRC_PER_Q + KIND_PAU] = res_wr && (res_queue == QW'(q)) && res_pause;

    p_cmp_set_r1: assert property (@(posedge clk) disable iff (rst)
      (res_wr && res_queue == QW'(q) && res_last) |=> flags[q*SRC_PER_Q + KIND_CMP])
      else $error("p_cmp_set_r1");

    p_pau_set_r2: assert property (@(posedge clk) disable iff (rst)
      (res_wr && res_queue == QW'(q) && res_pause) |=> flags[q*SRC_PER_Q + KIND_PAU])
      else $error("p_pau_set_r2");
  end

  // set has priority over a software clear in the same cycle
  always_ff @(posedge clk) begin
    if (rst) flags <= '0;
    else     flags <= (flags & ~flag_clr) | flag_set;
  end

  for (genvar i = 0; i < NS; i++) begin : g_chk
    p_clear_r3: assert property (@(posedge clk) disable iff (rst)
      (flag_clr[i] && !flag_set[i]) |=> !flags[i])
      else $error("p_clear_r3");
  end

  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!res_wr && flag_clr == '0) |=> $stable(flags))
    else $error("p_hold_r3");
endmodule

// File: rtl/qirq_resolve.sv
module qirq_resolve
  import qirq_pkg::*;
#(
  parameter int NQ    = 2,
  parameter int LVL_W = 3,
  parameter int VEC_W = 8,
  localparam int NS   = NQ * SRC_PER_Q,
  localparam int IW   = $clog2(NS),
  localparam int BW   = VEC_W - IW
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NS-1:0]             flags,
  input  logic [NS-1:0]             src_en,
  input  logic [NQ-1:0][LVL_W-1:0]  q_level,
  input  logic [BW-1:0]             vec_base,
  input  logic                      iack,
  input  logic [LVL_W-1:0]          iack_level,
  output logic [LVL_W-1:0]          irq_level,
  output logic                      iack_resp,
  output logic [VEC_W-1:0]          iack_vec
);
  logic [NS-1:0]    active;
  logic [LVL_W-1:0] max_lvl;
  logic             hit;
  logic [IW-1:0]    win;

  // a source requests only if flagged, enabled and its queue is not muted
  for (genvar i = 0; i < NS; i++) begin : g_act
    assign active[i] = flags[i] && src_en[i] && (q_level[i / SRC_PER_Q] != '0);
  end

  always_comb begin
    max_lvl = '0;
    for (int q = 0; q < NQ; q++) begin
      if ((active[q*SRC_PER_Q + KIND_CMP] || active[q*SRC_PER_Q + KIND_PAU])
          && q_level[q] > max_lvl)
        max_lvl = q_level[q];
    end
  end

  // descending scan: the lowest matching index is the last one kept
  always_comb begin
    hit = 1'b0;
    win = '0;
    for (int i = NS - 1; i >= 0; i--) begin
      if (active[i] && q_level[i / SRC_PER_Q] == iack_level) begin
        hit = 1'b1;
        win = IW'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_level <= '0;
      iack_resp <= 1'b0;
      iack_vec  <= '0;
    end else begin
      irq_level <= max_lvl;
      iack_resp <= iack && hit;
      iack_vec  <= (iack && hit) ? {vec_base, win} : '0;
    end
  end

  p_idle_r4: assert property (@(posedge clk) disable iff (rst)
    ((flags & src_en) == '0) |=> (irq_level == '0))
    else $error("p_idle_r4");

  p_resp_needs_ack_r7: assert property (@(posedge clk) disable iff (rst)
    iack_resp |-> $past(iack))
    else $error("p_resp_needs_ack_r7");

  p_zero_level_r5: assert property (@(posedge clk) disable iff (rst)
    (iack && iack_level == '0) |=> !iack_resp)
    else $error("p_zero_level_r5");

  p_quiet_vec_r9: assert property (@(posedge clk) disable iff (rst)
    !iack_resp |-> (iack_vec == '0))
    else $error("p_quiet_vec_r9");
endmodule

// File: rtl/qirq_arbiter.sv
module qirq_arbiter
  import qirq_pkg::*;
#(
  parameter int NQ    = 2,
  parameter int LVL_W = 3,
  parameter int DW    = 8,
  parameter int VEC_W = 8,
  localparam int NS   = NQ * SRC_PER_Q,
  localparam int IW   = $clog2(NS),
  localparam int BW   = VEC_W - IW,
  localparam int QW   = (NQ > 1) ? $clog2(NQ) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  input  logic             res_wr,
  input  logic [QW-1:0]    res_queue,
  input  logic             res_last,
  input  logic             res_pause,
  output logic [LVL_W-1:0] irq_level,
  input  logic             iack,
  input  logic [LVL_W-1:0] iack_level,
  output logic             iack_resp,
  output logic [VEC_W-1:0] iack_vec
);
  logic [NS-1:0]            flags;
  logic [NS-1:0]            flag_clr;
  logic [NS-1:0]            src_en;
  logic [NQ-1:0][LVL_W-1:0] q_level;
  logic [BW-1:0]            vec_base;

  qirq_regs #(.NQ(NQ), .LVL_W(LVL_W), .DW(DW), .VEC_W(VEC_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .flags     (flags),
    .q_level   (q_level),
    .src_en    (src_en),
    .vec_base  (vec_base),
    .flag_clr  (flag_clr),
    .reg_rdata (reg_rdata)
  );

  qirq_flags #(.NQ(NQ)) u_flags (
    .clk       (clk),
    .rst       (rst),
    .res_wr    (res_wr),
    .res_queue (res_queue),
    .res_last  (res_last),
    .res_pause (res_pause),
    .flag_clr  (flag_clr),
    .flags     (flags)
  );

  qirq_resolve #(.NQ(NQ), .LVL_W(LVL_W), .VEC_W(VEC_W)) u_resolve (
    .clk        (clk),
    .rst        (rst),
    .flags      (flags),
    .src_en     (src_en),
    .q_level    (q_level),
    .vec_base   (vec_base),
    .iack       (iack),
    .iack_level (iack_level),
    .irq_level  (irq_level),
    .iack_resp  (iack_resp),
    .iack_vec   (iack_vec)
  );
endmodule

// File: tb/tb_qirq_arbiter.sv
`timescale 1ns/1ps
module tb_qirq_arbiter;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       res_wr = 1'b0;
  logic [0:0] res_queue = '0;
  logic       res_last = 1'b0;
  logic       res_pause = 1'b0;
  logic [2:0] irq_level;
  logic       iack = 1'b0;
  logic [2:0] iack_level = '0;
  logic       iack_resp;
  logic [7:0] iack_vec;

  always #2.5 clk = ~clk;

  qirq_arbiter dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .res_wr(res_wr),
    .res_queue(res_queue), .res_last(res_last), .res_pause(res_pause),
    .irq_level(irq_level), .iack(iack), .iack_level(iack_level),
    .iack_resp(iack_resp), .iack_vec(iack_vec)
  );

  int tests = 0;
  int fails = 0;
  int cyc   = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // scoreboard: kind 0 = irq_level, 1 = {iack_resp,iack_vec}, 2 = reg_rdata
  int         due_q[$];
  int         kind_q[$];
  logic [8:0] exp_q[$];
  string      req_q[$];

  task automatic push(int kind, logic [8:0] e, string r);
    due_q.push_back(cyc + 1);
    kind_q.push_back(kind);
    exp_q.push_back(e);
    req_q.push_back(r);
  endtask

  always @(negedge clk) begin
    while (due_q.size() > 0 && due_q[0] <= cyc) begin
      int k;
      logic [8:0] e;
      logic [8:0] a;
      string r;
      int d;
      d = due_q.pop_front();
      k = kind_q.pop_front();
      e = exp_q.pop_front();
      r = req_q.pop_front();
      case (k)
        0:       a = {6'd0, irq_level};
        1:       a = {iack_resp, iack_vec};
        default: a = {1'b0, reg_rdata};
      endcase
      tests++;
      if (d != cyc || a !== e) begin
        fails++;
        $display("FAIL %s: kind %0d actual %h expected %h", r, k, a, e);
      end
    end
  end

  task automatic tick(); @(negedge clk); endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(logic [1:0] a, logic [7:0] e, string r);
    reg_addr = a;
    push(2, {1'b0, e}, r);
    tick();
  endtask

  task automatic strobe(logic q, logic l, logic p);
    res_wr = 1'b1; res_queue = q; res_last = l; res_pause = p;
    tick();
    res_wr = 1'b0; res_last = 1'b0; res_pause = 1'b0;
  endtask

  task automatic lvl_chk(logic [2:0] e, string r);
    push(0, {6'd0, e}, r);
    tick();
  endtask

  task automatic ack_chk(logic [2:0] l, logic resp, logic [7:0] v, string r);
    iack = 1'b1; iack_level = l;
    push(1, {resp, v}, r);
    tick();
    iack = 1'b0;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    tick();
    // reset state (R4, R10)
    lvl_chk(3'd0, "R4 reset");
    rd_chk(2'd0, 8'h00, "R10 reset level");
    rd_chk(2'd1, 8'h00, "R10 reset enable");
    rd_chk(2'd2, 8'h00, "R10 reset flags");
    rd_chk(2'd3, 8'h00, "R10 reset vbase");

    // configure: first queue level 3, second level 5, all enabled, base 0x40
    wr(2'd0, 8'h2B);
    wr(2'd1, 8'h0F);
    wr(2'd3, 8'h40);
    rd_chk(2'd0, 8'h2B, "R10 level readback");
    rd_chk(2'd3, 8'h40, "R10 vbase readback");

    strobe(1'b0, 1'b1, 1'b0);                  // R1
    lvl_chk(3'd3, "R4 single source");
    rd_chk(2'd2, 8'h01, "R1 completion flag");
    strobe(1'b1, 1'b0, 1'b1);                  // R2
    lvl_chk(3'd5, "R4 max of levels");
    rd_chk(2'd2, 8'h09, "R2 pause flag");

    ack_chk(3'd5, 1'b1, 8'h43, "R7 second queue pause vector");
    ack_chk(3'd3, 1'b1, 8'h40, "R7 first queue completion vector");
    ack_chk(3'd4, 1'b0, 8'h00, "R9 unmatched level");

    strobe(1'b0, 1'b0, 1'b1);
    ack_chk(3'd3, 1'b1, 8'h40, "R8 completion over pause");
    wr(2'd2, 8'h01);
    rd_chk(2'd2, 8'h0A, "R3 write-one clear");
    ack_chk(3'd3, 1'b1, 8'h41, "R8 pause after clear");

    // equal levels, both queues pending on pause
    wr(2'd0, 8'h1B);
    ack_chk(3'd3, 1'b1, 8'h41, "R8 first queue wins shared level");
    ack_chk(3'd5, 1'b0, 8'h00, "R9 stale level");

    wr(2'd2, 8'h0F);
    lvl_chk(3'd0, "R4 idle after clear");
    rd_chk(2'd2, 8'h00, "R3 clear all");

    // set and clear of one flag in the same cycle
    wr(2'd0, 8'h2B);
    strobe(1'b1, 1'b1, 1'b0);
    lvl_chk(3'd5, "R4 second queue completion");
    res_wr = 1'b1; res_queue = 1'b1; res_last = 1'b1;
    wr(2'd2, 8'h04);
    res_wr = 1'b0; res_last = 1'b0;
    rd_chk(2'd2, 8'h04, "R3 set wins over clear");
    lvl_chk(3'd5, "R3 request kept after collision");
    wr(2'd2, 8'h00);
    rd_chk(2'd2, 8'h04, "R3 zero write ignored");

    // muted queue
    wr(2'd0, 8'h03);
    lvl_chk(3'd0, "R5 muted queue no request");
    ack_chk(3'd0, 1'b0, 8'h00, "R5 level zero ack");
    ack_chk(3'd3, 1'b0, 8'h00, "R5 no muted response");
    rd_chk(2'd2, 8'h04, "R5 flag retained");

    // enables
    wr(2'd0, 8'h33);
    wr(2'd1, 8'h0A);
    lvl_chk(3'd0, "R6 completion disabled");
    strobe(1'b0, 1'b1, 1'b0);
    rd_chk(2'd2, 8'h05, "R6 flag sets while disabled");
    lvl_chk(3'd0, "R6 still no request");
    ack_chk(3'd6, 1'b0, 8'h00, "R6 no ack while disabled");
    wr(2'd1, 8'h0F);
    lvl_chk(3'd6, "R6 enable raises request");
    ack_chk(3'd3, 1'b1, 8'h40, "R7 first queue at level 3");
    ack_chk(3'd6, 1'b1, 8'h42, "R7 second queue completion vector");

    // both markers in one strobe
    wr(2'd2, 8'h0F);
    strobe(1'b0, 1'b1, 1'b1);
    rd_chk(2'd2, 8'h03, "R2 both markers first queue");
    strobe(1'b1, 1'b1, 1'b1);
    rd_chk(2'd2, 8'h0F, "R2 both markers second queue");
    ack_chk(3'd6, 1'b1, 8'h42, "R8 completion first in second queue");

    repeat (3) tick();
    if (due_q.size() != 0) begin
      tests++; fails++;
      $display("FAIL scoreboard: actual %0d pending expected 0", due_q.size());
    end
    finish_run();
  end
endmodule